// File: doc/BRIEF.md
# Interrupt Source Capture and Enable Bank

This block takes a bank of asynchronous interrupt request lines and turns them into a vector of pending requests. Each line passes through a two-flop synchroniser. A per-source type bit selects level or edge sensing, and a per-source polarity bit selects the active sense. The sensed result is kept in a raw status bit. Each status bit is gated by a per-source enable to form the pending output.

Software reaches the bank through a plain write strobe and a combinational read port. Each 32-bit register word covers sources 32·w to 32·w+31. Enables and status can be set or cleared by mask words, where a one bit acts and a zero bit leaves the bit alone. They can also be set or cleared by writing one source number to an index register, so no read-modify-write is needed.

The address is five bits. Bits [4:2] select the function: 0 polarity, 1 type, 2 enable-set, 3 enable-clear, 4 status-set, 5 status-clear, 6 pending, 7 index. Bits [1:0] select the word. For the index function, bits [1:0] select the operation instead: 0 enable set, 1 enable clear, 2 status set, 3 status clear.

Top module: `ic_capture_bank`

## Requirements
- R1: A change on an input line reaches its status bit on the third rising clock edge after it is driven. It does not reach it on the second.
- R2: In level mode (type bit 0), the status bit follows the synchronised line. It is 1 while the line equals the polarity bit (1 = active-high, 0 = active-low).
- R3: In edge mode (type bit 1), the status bit sets on a rising edge when polarity is 1 and on a falling edge when polarity is 0. It then stays set until cleared. A change of polarity alone is not an edge.
- R4: When a selected edge and a status clear of the same source fall in the same cycle, the status bit stays set.
- R5: Mask writes act per word. A 1 bit at enable-set enables the source, and a 1 bit at enable-clear disables it. A 1 bit at status-clear clears the status of an edge source. A 1 bit at status-set sets the status of an edge source and has no effect on a level source. Writing all ones to a clear word clears the whole word.
- R6: A write to an index register acts only on source N = wr_data. The operations are enable set, enable clear, status set and status clear. A value N of NUM_SRC or more is ignored.
- R7: Pending is status AND enable. It appears on irq_pending and is readable as word w at function 6.
- R8: Source N has its polarity and type bits at word N/32, bit N%32, and both read back as written. Reads of enable-set and enable-clear return the enables, and reads of status-set and status-clear return the status. Writes to the pending function are ignored.
- R9: Reset clears polarity, type, enable, status and the synchronisers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | NUM_SRC | Asynchronous interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address: function [4:2], word or index op [1:0] |
| wr_data | input | 32 | Write data: mask word or source number |
| rd_addr | input | 5 | Read address, same layout as wr_addr |
| rd_data | output | 32 | Combinational read data |
| irq_pending | output | NUM_SRC | Status AND enable per source |

## Verification
The assertions assume two things. First, register writes are synchronous to clk. Second, each interrupt line holds a level for at least two clock cycles, so that the synchroniser sees every edge once. The stimulus changes lines only on falling clock edges and holds every line for at least four cycles before it samples. The one exception is the same-cycle edge and clear case, where the clear strobe is placed on the one cycle in which the edge is detected.

// File: rtl/ic_pkg.sv
`timescale 1ns/1ps
package ic_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 5;
    localparam int SEL_W  = 2;

    typedef enum logic [2:0] {
        FN_POL    = 3'd0,
        FN_TYPE   = 3'd1,
        FN_EN_SET = 3'd2,
        FN_EN_CLR = 3'd3,
        FN_ST_SET = 3'd4,
        FN_ST_CLR = 3'd5,
        FN_PEND   = 3'd6,
        FN_INDEX  = 3'd7
    } fn_e;

    typedef enum logic [1:0] {
        IX_EN_SET = 2'd0,
        IX_EN_CLR = 2'd1,
        IX_ST_SET = 2'd2,
        IX_ST_CLR = 2'd3
    } ix_e;
endpackage

// File: rtl/ic_sync.sv
`timescale 1ns/1ps
module ic_sync #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prev
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_in;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sync_d;
    end

    assign lvl  = sync_q.s2;
    assign prev = sync_q.s3;
endmodule

// File: rtl/ic_src_cell.sv
`timescale 1ns/1ps
module ic_src_cell (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic prev,
    input  logic pol,
    input  logic edge_mode,
    input  logic sw_set,
    input  logic sw_clr,
    output logic status
);
    typedef struct packed {
        logic status;
        logic live;
    } cell_t;

    cell_t cell_d, cell_q;
    logic  hit;

    assign hit = pol ? (lvl & ~prev) : (~lvl & prev);

    always_comb begin
        cell_d      = cell_q;
        cell_d.live = 1'b1;
        if (!edge_mode) cell_d.status = (lvl == pol);
        else            cell_d.status = hit | sw_set | (cell_q.status & ~sw_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) cell_q <= '0;
        else     cell_q <= cell_d;
    end

    assign status = cell_q.status;

    p_level_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (cell_q.live && !edge_mode) |=> (status == $past(lvl == pol)));

    p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cell_q.live && edge_mode && status && !sw_clr) |=> status);

    p_edge_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (cell_q.live && edge_mode && hit && sw_clr) |=> status);

    p_edge_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (cell_q.live && edge_mode && sw_clr && !hit && !sw_set) |=> !status);
endmodule

// File: rtl/ic_regs.sv
`timescale 1ns/1ps
module ic_regs
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [NUM_SRC-1:0] status,
    output logic [NUM_SRC-1:0] pol,
    output logic [NUM_SRC-1:0] typ,
    output logic [NUM_SRC-1:0] enable,
    output logic [NUM_SRC-1:0] st_set,
    output logic [NUM_SRC-1:0] st_clr,
    output logic [WORD_W-1:0]  rd_data
);
    localparam int NWORDS = (NUM_SRC + WORD_W - 1) / WORD_W;
    localparam int PAD    = NWORDS * WORD_W;
    localparam int IDX_W  = $clog2(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0] pol;
        logic [NUM_SRC-1:0] typ;
        logic [NUM_SRC-1:0] en;
        logic               live;
    } regs_t;

    regs_t regs_d, regs_q;

    fn_e              wfn, rfn;
    logic [SEL_W-1:0] wsel;
    logic             idx_ok;
    logic [IDX_W-1:0] idx;
    logic [PAD-1:0]   pol_p, typ_p, en_p, st_p, pend_p;

    always_comb begin
        wfn    = fn_e'(wr_addr[ADDR_W-1:SEL_W]);
        wsel   = wr_addr[SEL_W-1:0];
        idx_ok = wr_data < WORD_W'(NUM_SRC);
        idx    = wr_data[IDX_W-1:0];
        regs_d      = regs_q;
        regs_d.live = 1'b1;
        st_set      = '0;
        st_clr      = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (wr_en && wsel == SEL_W'(s / WORD_W)) begin
                case (wfn)
                    FN_POL:    regs_d.pol[s] = wr_data[s % WORD_W];
                    FN_TYPE:   regs_d.typ[s] = wr_data[s % WORD_W];
                    FN_EN_SET: if (wr_data[s % WORD_W]) regs_d.en[s] = 1'b1;
                    FN_EN_CLR: if (wr_data[s % WORD_W]) regs_d.en[s] = 1'b0;
                    FN_ST_SET: st_set[s] = wr_data[s % WORD_W];
                    FN_ST_CLR: st_clr[s] = wr_data[s % WORD_W];
                    default: ;
                endcase
            end
            if (wr_en && wfn == FN_INDEX && idx_ok && idx == IDX_W'(s)) begin
                case (ix_e'(wsel))
                    IX_EN_SET: regs_d.en[s] = 1'b1;
                    IX_EN_CLR: regs_d.en[s] = 1'b0;
                    IX_ST_SET: st_set[s] = 1'b1;
                    IX_ST_CLR: st_clr[s] = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign pol    = regs_q.pol;
    assign typ    = regs_q.typ;
    assign enable = regs_q.en;

    always_comb begin
        pol_p  = '0;
        typ_p  = '0;
        en_p   = '0;
        st_p   = '0;
        pol_p[NUM_SRC-1:0]  = regs_q.pol;
        typ_p[NUM_SRC-1:0]  = regs_q.typ;
        en_p[NUM_SRC-1:0]   = regs_q.en;
        st_p[NUM_SRC-1:0]   = status;
        pend_p = st_p & en_p;
        rfn     = fn_e'(rd_addr[ADDR_W-1:SEL_W]);
        rd_data = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (rd_addr[SEL_W-1:0] == SEL_W'(w)) begin
                case (rfn)
                    FN_POL:                 rd_data = pol_p[w*WORD_W +: WORD_W];
                    FN_TYPE:                rd_data = typ_p[w*WORD_W +: WORD_W];
                    FN_EN_SET, FN_EN_CLR:   rd_data = en_p[w*WORD_W +: WORD_W];
                    FN_ST_SET, FN_ST_CLR:   rd_data = st_p[w*WORD_W +: WORD_W];
                    FN_PEND:                rd_data = pend_p[w*WORD_W +: WORD_W];
                    default:                rd_data = '0;
                endcase
            end
        end
    end

    p_idx_en_set_r6: assert property (@(posedge clk) disable iff (rst)
        (regs_q.live && wr_en && wr_addr == {FN_INDEX, IX_EN_SET} && wr_data < WORD_W'(NUM_SRC))
        |=> regs_q.en[$past(wr_data[IDX_W-1:0])]);

    p_idx_en_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (regs_q.live && wr_en && wr_addr == {FN_INDEX, IX_EN_CLR} && wr_data < WORD_W'(NUM_SRC))
        |=> !regs_q.en[$past(wr_data[IDX_W-1:0])]);

    p_mask_clr_all_r5: assert property (@(posedge clk) disable iff (rst)
        (regs_q.live && wr_en && wr_addr == {FN_EN_CLR, 2'd0} && wr_data == '1)
        |=> (en_p[WORD_W-1:0] == '0));

    p_idx_range_r6: assert property (@(posedge clk) disable iff (rst)
        (regs_q.live && wr_en && wr_addr[ADDR_W-1:SEL_W] == FN_INDEX && wr_data >= WORD_W'(NUM_SRC))
        |=> $stable(regs_q.en));
endmodule

// File: rtl/ic_capture_bank.sv
`timescale 1ns/1ps
module ic_capture_bank
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               wr_en,
    input  logic [4:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [4:0]         rd_addr,
    output logic [31:0]        rd_data,
    output logic [NUM_SRC-1:0] irq_pending
);
    logic [NUM_SRC-1:0] lvl, prev, pol, typ, enable, st_set, st_clr, status;

    ic_sync #(.N(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_in),
        .lvl      (lvl),
        .prev     (prev)
    );

    ic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .status  (status),
        .pol     (pol),
        .typ     (typ),
        .enable  (enable),
        .st_set  (st_set),
        .st_clr  (st_clr),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        ic_src_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .lvl       (lvl[g]),
            .prev      (prev[g]),
            .pol       (pol[g]),
            .edge_mode (typ[g]),
            .sw_set    (st_set[g]),
            .sw_clr    (st_clr[g]),
            .status    (status[g])
        );
    end

    assign irq_pending = status & enable;
endmodule

// File: tb/sim_ic_capture_bank.sv
`timescale 1ns/1ps
module sim_ic_capture_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] irq_pending;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    ic_capture_bank #(.NUM_SRC(64)) u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_pending(irq_pending)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [63:0] irq;
        logic [4:0]  ra;
        logic [31:0] exp;
    } vec_t;

    // address = {function[2:0], word or index op[1:0]}
    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{"R2", 1'b1, 5'd0,  32'hFFFF_FFFF, 64'h0,                   5'd16, 32'h0000_0000},
        '{"R2", 1'b1, 5'd1,  32'hFFFF_FFFF, 64'h0,                   5'd17, 32'h0000_0000},
        '{"R3", 1'b1, 5'd4,  32'h0000_FFFF, 64'h0,                   5'd16, 32'h0000_0000},
        '{"R3", 1'b0, 5'd0,  32'h0,         64'h0000_0000_000F_000F, 5'd16, 32'h000F_000F},
        '{"R2", 1'b0, 5'd0,  32'h0,         64'h0,                   5'd16, 32'h0000_000F},
        '{"R7", 1'b1, 5'd8,  32'h0001_0001, 64'h0,                   5'd24, 32'h0000_0001},
        '{"R6", 1'b1, 5'd28, 32'd2,         64'h0,                   5'd24, 32'h0000_0005},
        '{"R6", 1'b1, 5'd31, 32'd0,         64'h0,                   5'd16, 32'h0000_000E},
        '{"R5", 1'b1, 5'd20, 32'hFFFF_FFFF, 64'h0,                   5'd16, 32'h0000_0000},
        '{"R5", 1'b1, 5'd16, 32'h0001_0010, 64'h0,                   5'd16, 32'h0000_0010},
        '{"R3", 1'b1, 5'd5,  32'hFFFF_FFFF, 64'h0,                   5'd17, 32'h0000_0000},
        '{"R3", 1'b0, 5'd0,  32'h0,         64'h8000_0001_0000_0000, 5'd17, 32'h8000_0001},
        '{"R6", 1'b1, 5'd28, 32'd63,        64'h8000_0001_0000_0000, 5'd25, 32'h8000_0000},
        '{"R6", 1'b1, 5'd29, 32'd63,        64'h8000_0001_0000_0000, 5'd25, 32'h0000_0000},
        '{"R6", 1'b1, 5'd28, 32'd65,        64'h8000_0001_0000_0000, 5'd8,  32'h0001_0005},
        '{"R5", 1'b1, 5'd12, 32'hFFFF_FFFF, 64'h8000_0001_0000_0000, 5'd8,  32'h0000_0000},
        '{"R5", 1'b1, 5'd21, 32'hFFFF_FFFF, 64'h8000_0001_0000_0000, 5'd17, 32'h0000_0000},
        '{"R3", 1'b1, 5'd1,  32'h0000_0000, 64'h8000_0001_0000_0000, 5'd17, 32'h0000_0000},
        '{"R3", 1'b0, 5'd0,  32'h0,         64'h0,                   5'd17, 32'h8000_0001},
        '{"R2", 1'b1, 5'd0,  32'h0000_0000, 64'h0,                   5'd16, 32'hFFFF_0010},
        '{"R8", 1'b1, 5'd1,  32'h0000_A5A5, 64'h0,                   5'd1,  32'h0000_A5A5},
        '{"R8", 1'b1, 5'd24, 32'hFFFF_FFFF, 64'h0,                   5'd24, 32'h0000_0000},
        '{"R7", 1'b1, 5'd9,  32'h0000_0001, 64'h0,                   5'd25, 32'h0000_0001}
    };

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        // R9: reset state while reset is held
        repeat (3) @(negedge clk);
        rd_addr = 5'd8;  #1 check("R9", "enable word0 in reset", {32'h0, rd_data}, 64'h0);
        rd_addr = 5'd16; #1 check("R9", "status word0 in reset", {32'h0, rd_data}, 64'h0);
        rd_addr = 5'd4;  #1 check("R9", "type word0 in reset", {32'h0, rd_data}, 64'h0);
        check("R9", "pending in reset", irq_pending, 64'h0);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            irq_in  = TBL[i].irq;
            wr_en   = TBL[i].we;
            wr_addr = TBL[i].wa;
            wr_data = TBL[i].wd;
            @(negedge clk);
            wr_en = 1'b0;
            repeat (3) @(negedge clk);
            rd_addr = TBL[i].ra;
            #1 check(string'(TBL[i].tag), $sformatf("vector %0d", i), {32'h0, rd_data}, {32'h0, TBL[i].exp});
        end

        // R7: pending vector port (source 32 status and enable set)
        check("R7", "irq_pending port", irq_pending, 64'h0000_0001_0000_0000);

        // R1: source 20 is level active-low and starts at status 1
        @(negedge clk);
        irq_in[20] = 1'b1;
        rd_addr = 5'd16;
        @(negedge clk);
        @(negedge clk);
        #1 check("R1", "status bit20 after two edges", {63'h0, rd_data[20]}, 64'h1);
        @(negedge clk);
        #1 check("R1", "status bit20 after three edges", {63'h0, rd_data[20]}, 64'h0);

        // R4: source 5 is edge mode, falling; clear lands in the detect cycle
        @(negedge clk);
        irq_in[5] = 1'b1;
        repeat (4) @(negedge clk);
        #1 check("R3", "rising edge ignored when falling selected", {63'h0, rd_data[5]}, 64'h0);
        irq_in[5] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd31; wr_data = 32'd5;
        @(negedge clk);
        wr_en = 1'b0;
        rd_addr = 5'd16;
        #1 check("R4", "edge beats same-cycle clear", {63'h0, rd_data[5]}, 64'h1);
        do_write(5'd31, 32'd5);
        #1 check("R6", "indexed clear of source 5", {63'h0, rd_data[5]}, 64'h0);

        // R6: indexed status set on an edge source
        do_write(5'd30, 32'd6);
        #1 check("R6", "indexed status set of source 6", {63'h0, rd_data[6]}, 64'h1);

        // R9: reset mid-run clears configuration
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_addr = 5'd1;  #1 check("R9", "polarity word1 after reset", {32'h0, rd_data}, 64'h0);
        rd_addr = 5'd9;  #1 check("R9", "enable word1 after reset", {32'h0, rd_data}, 64'h0);
        check("R9", "pending after reset", irq_pending, 64'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule